// File: doc/BRIEF.md
# ATM cell header rewriter

This block sits in line on a byte-wide ATM cell stream. It collects the five header bytes of each incoming cell and builds a 28-bit connection key from the path and channel identifier fields. It then asks an external lookup engine for the translation of that key. On a hit it sends the cell onward with the identifier fields replaced. When configured, one to three routing-tag bytes are placed ahead of the header. The loss-priority and congestion bits are updated as the entry requests, and the header check byte is regenerated. The 48 payload bytes follow unchanged. A cell whose key misses in the table is discarded whole, and a counter records the loss.

Both streams use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. A source that has raised valid must hold valid, the data and the start-of-cell flag until the byte is taken, and the same rule binds this block on its output. During payload, input ready follows output ready, so back-pressure passes straight through. During header collection and during a discarded cell, input ready is high. While the lookup is pending and while the tag and header are being sent, input ready is low. The lookup side is plain control: a request held level and a one-cycle response strobe.

Top module: `atm_cell_rewriter`

## Requirements
- R1: The lookup key is {byte0, byte1, byte2, byte3[7:4]} of the incoming header when `nni_mode`=1. When `nni_mode`=0, key[27:24] is zero and key[23:0] is {byte0[3:0], byte1, byte2, byte3[7:4]}.
- R2: On a hit, output header bytes 1 and 2 and byte3[7:4] come from `lk_new_id[19:0]`. With `nni_mode`=1, byte0 is `lk_new_id[27:20]`. With `nni_mode`=0, byte0 keeps its incoming upper nibble and takes `lk_new_id[23:20]` in its lower nibble.
- R3: Output byte3 bit 0 (loss priority) follows `lk_clp_ctl` and bit 2 (congestion) follows `lk_cong_ctl`. For each: code 1 sets the bit, code 2 clears it, and codes 0 and 3 keep the incoming value. Bits 1 and 3 are copied unchanged.
- R4: With `hec_pass`=0, output header byte 4 is the CRC-8 of the four output header bytes (generator x^8+x^2+x+1, zero initial value, first byte most significant bit first) XOR 0x55. With `hec_pass`=1 it is the incoming byte 4.
- R5: With `tag_size`=n (0..3), n tag bytes come before the header, taken from `lk_tag` in the order [8n-1:8n-8] down to [7:0]. n=0 sends no tag.
- R6: `out_soc` is high on the first output byte of each forwarded cell (the first tag byte when n>0) and low on every other byte.
- R7: A forwarded cell's 48 payload bytes appear in their input order with their values unchanged, so a forwarded cell has exactly 53+n output bytes.
- R8: On a miss (`lk_hit`=0), no byte of that cell is sent and `drop_count` (zero after reset) rises by exactly one.
- R9: `lk_req` rises after the fifth header byte is accepted. It stays high with `lk_key` stable until the cycle in which `lk_rsp_valid` is high. While it is high, `in_ready` and `out_valid` are low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_soc` keep their values on the next cycle.
- R11: Bytes that arrive with `in_soc`=0 while no header is in progress are discarded. A byte with `in_soc`=1 during header collection restarts collection, and the abandoned partial header makes no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nni_mode | input | 1 | 1: network-node header layout, 0: user-network layout |
| hec_pass | input | 1 | 1: pass the incoming check byte, 0: regenerate it |
| tag_size | input | 2 | Routing tag length in bytes, 0..3 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| in_soc | input | 1 | Input byte is the first of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts an output byte |
| out_data | output | 8 | Output byte |
| out_soc | output | 1 | Output byte is the first of a cell |
| lk_req | output | 1 | Lookup request, held until answered |
| lk_key | output | 28 | Lookup key |
| lk_rsp_valid | input | 1 | One-cycle lookup answer strobe |
| lk_hit | input | 1 | Entry found |
| lk_new_id | input | 28 | Replacement path/channel identifier |
| lk_tag | input | 24 | Routing tag bytes |
| lk_clp_ctl | input | 2 | Loss-priority control code |
| lk_cong_ctl | input | 2 | Congestion control code |
| drop_count | output | 16 | Count of cells discarded on a miss |

## Verification
A wrong header index or state shows first as a wrong `lk_key`, which is visible in the very cycle `lk_req` rises, well before any output byte. A fault in the emit buffer or the tag count shifts every later byte of that cell. It then shows as a wrong first byte, a misplaced `out_soc` or a wrong output byte count when the cell completes. A payload counter that is off by even one merges or splits cells, so the next cell's lookup key and start flag go wrong within one cell time. The sweep covers every combination of layout, check-byte mode, tag length and both mark codes, with random output stalls and varying lookup latency.

// File: rtl/atm_rw_pkg.sv
package atm_rw_pkg;

  localparam int HDR_BYTES = 5;
  localparam int KEY_W     = 28;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_LOOK,
    ST_EMIT,
    ST_PAY,
    ST_DROP
  } rw_state_e;

  // 1 = force high, 2 = force low, anything else keeps the bit
  function automatic logic apply_mark(input logic [1:0] code, input logic cur);
    case (code)
      2'd1:    apply_mark = 1'b1;
      2'd2:    apply_mark = 1'b0;
      default: apply_mark = cur;
    endcase
  endfunction

  // serial CRC-8, generator 0x07, zero start, MSB first
  function automatic logic [7:0] hdr_crc8(input logic [31:0] word);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ word[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    hdr_crc8 = c;
  endfunction

endpackage

// File: rtl/atm_rw_key.sv
module atm_rw_key
  import atm_rw_pkg::*;
(
  input  logic [31:0]      hdr_word,
  input  logic             nni_mode,
  output logic [KEY_W-1:0] key
);
  always_comb begin
    key = hdr_word[31:4];
    if (!nni_mode) key[27:24] = 4'h0;
  end
endmodule

// File: rtl/atm_rw_hdr_build.sv
module atm_rw_hdr_build
  import atm_rw_pkg::*;
(
  input  logic [31:0]      hdr_word,
  input  logic [7:0]       hec_in,
  input  logic             nni_mode,
  input  logic             hec_pass,
  input  logic [KEY_W-1:0] new_id,
  input  logic [1:0]       clp_ctl,
  input  logic [1:0]       cong_ctl,
  output logic [31:0]      new_word,
  output logic [7:0]       new_hec
);
  logic [3:0] low_nib;

  always_comb begin
    new_word[31:4] = new_id;
    if (!nni_mode) new_word[31:28] = hdr_word[31:28];
    low_nib    = hdr_word[3:0];
    low_nib[0] = apply_mark(clp_ctl, hdr_word[0]);
    low_nib[2] = apply_mark(cong_ctl, hdr_word[2]);
    new_word[3:0] = low_nib;
  end

  assign new_hec = hec_pass ? hec_in : (hdr_crc8(new_word) ^ 8'h55);
endmodule

// File: rtl/atm_rw_emit_buf.sv
module atm_rw_emit_buf
  import atm_rw_pkg::*;
#(
  parameter int TAG_MAX = 3,
  localparam int TS_W  = $clog2(TAG_MAX + 1),
  localparam int SLOTS = TAG_MAX + HDR_BYTES
) (
  input  logic [8*TAG_MAX-1:0] tag_vec,
  input  logic [TS_W-1:0]      tag_n,
  input  logic [31:0]          hdr_word,
  input  logic [7:0]           hec,
  output logic [8*SLOTS-1:0]   slots
);
  logic [7:0] hbytes [HDR_BYTES];

  always_comb begin
    for (int h = 0; h < 4; h++) hbytes[h] = hdr_word[8*(3-h) +: 8];
    hbytes[4] = hec;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] slot_b;
    always_comb begin
      int tn;
      tn     = int'(tag_n);
      slot_b = '0;
      for (int j = 0; j < TAG_MAX; j++)
        if (g < tn && j == tn - 1 - g) slot_b = tag_vec[8*j +: 8];
      for (int h = 0; h < HDR_BYTES; h++)
        if (g == tn + h) slot_b = hbytes[h];
    end
    assign slots[8*g +: 8] = slot_b;
  end
endmodule

// File: rtl/atm_cell_rewriter.sv
module atm_cell_rewriter
  import atm_rw_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int TAG_MAX    = 3,
  parameter int CNT_W      = 16,
  localparam int TS_W      = $clog2(TAG_MAX + 1),
  localparam int TAG_W     = 8 * TAG_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nni_mode,
  input  logic             hec_pass,
  input  logic [TS_W-1:0]  tag_size,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_soc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_soc,
  output logic             lk_req,
  output logic [KEY_W-1:0] lk_key,
  input  logic             lk_rsp_valid,
  input  logic             lk_hit,
  input  logic [KEY_W-1:0] lk_new_id,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [1:0]       lk_clp_ctl,
  input  logic [1:0]       lk_cong_ctl,
  output logic [CNT_W-1:0] drop_count
);
  localparam int PAY_BYTES = CELL_BYTES - HDR_BYTES;
  localparam int PAY_W     = $clog2(PAY_BYTES);
  localparam int SLOTS     = TAG_MAX + HDR_BYTES;
  localparam int SLOT_W    = $clog2(SLOTS + 1);

  rw_state_e          state_q;
  logic [2:0]         hidx_q;
  logic [31:0]        hdr_q;
  logic [7:0]         hec_q;
  logic [SLOT_W-1:0]  oidx_q, elen_q;
  logic [8*SLOTS-1:0] ebuf_q;
  logic [PAY_W-1:0]   pcnt_q;
  logic [CNT_W-1:0]   drop_q;

  logic [31:0]        new_word;
  logic [7:0]         new_hec;
  logic [8*SLOTS-1:0] slots;
  logic               in_fire, out_fire;

  atm_rw_key i_key (
    .hdr_word (hdr_q),
    .nni_mode (nni_mode),
    .key      (lk_key)
  );

  atm_rw_hdr_build i_build (
    .hdr_word (hdr_q),
    .hec_in   (hec_q),
    .nni_mode (nni_mode),
    .hec_pass (hec_pass),
    .new_id   (lk_new_id),
    .clp_ctl  (lk_clp_ctl),
    .cong_ctl (lk_cong_ctl),
    .new_word (new_word),
    .new_hec  (new_hec)
  );

  atm_rw_emit_buf #(.TAG_MAX(TAG_MAX)) i_emit (
    .tag_vec  (lk_tag),
    .tag_n    (tag_size),
    .hdr_word (new_word),
    .hec      (new_hec),
    .slots    (slots)
  );

  // stream handshakes per state
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_soc   = 1'b0;
    lk_req    = 1'b0;
    case (state_q)
      ST_HDR:  in_ready = 1'b1;
      ST_LOOK: lk_req   = 1'b1;
      ST_EMIT: begin
        out_valid = 1'b1;
        out_data  = ebuf_q[{oidx_q, 3'b000} +: 8];
        out_soc   = (oidx_q == '0);
      end
      ST_PAY: begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
      end
      ST_DROP: in_ready = 1'b1;
      default: ;
    endcase
  end

  assign in_fire    = in_valid & in_ready;
  assign out_fire   = out_valid & out_ready;
  assign drop_count = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      hidx_q  <= '0;
      hdr_q   <= '0;
      hec_q   <= '0;
      oidx_q  <= '0;
      elen_q  <= '0;
      ebuf_q  <= '0;
      pcnt_q  <= '0;
      drop_q  <= '0;
    end else begin
      case (state_q)
        ST_HDR: if (in_fire) begin
          if (in_soc) begin
            hdr_q[31:24] <= in_data;
            hidx_q       <= 3'd1;
          end else if (hidx_q != 3'd0) begin
            case (hidx_q)
              3'd1:    hdr_q[23:16] <= in_data;
              3'd2:    hdr_q[15:8]  <= in_data;
              3'd3:    hdr_q[7:0]   <= in_data;
              default: hec_q        <= in_data;
            endcase
            if (hidx_q == 3'd4) begin
              hidx_q  <= '0;
              state_q <= ST_LOOK;
            end else begin
              hidx_q <= hidx_q + 3'd1;
            end
          end
        end
        ST_LOOK: if (lk_rsp_valid) begin
          pcnt_q <= '0;
          if (lk_hit) begin
            ebuf_q  <= slots;
            elen_q  <= SLOT_W'(tag_size) + SLOT_W'(HDR_BYTES);
            oidx_q  <= '0;
            state_q <= ST_EMIT;
          end else begin
            drop_q  <= drop_q + CNT_W'(1);
            state_q <= ST_DROP;
          end
        end
        ST_EMIT: if (out_fire) begin
          oidx_q <= oidx_q + SLOT_W'(1);
          if (oidx_q == elen_q - SLOT_W'(1)) state_q <= ST_PAY;
        end
        ST_PAY, ST_DROP: if (in_fire) begin
          pcnt_q <= pcnt_q + PAY_W'(1);
          if (pcnt_q == PAY_W'(PAY_BYTES - 1)) state_q <= ST_HDR;
        end
        default: state_q <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/atm_rw_checker.sv
module atm_rw_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nni_mode,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_soc,
  input logic             lk_req,
  input logic             lk_rsp_valid,
  input logic [27:0]      lk_key,
  input logic [CNT_W-1:0] drop_count
);
  assert_uni_key_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !nni_mode) |-> (lk_key[27:24] == 4'h0));

  assert_soc_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> out_valid);

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_rsp_valid) |=> (lk_req && $stable(lk_key)));

  assert_quiet_in_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (!in_ready && !out_valid));

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));
endmodule

bind atm_cell_rewriter atm_rw_checker #(.CNT_W(CNT_W)) i_rw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .nni_mode     (nni_mode),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_soc      (out_soc),
  .lk_req       (lk_req),
  .lk_rsp_valid (lk_rsp_valid),
  .lk_key       (lk_key),
  .drop_count   (drop_count)
);

// File: tb/test_atm_cell_rewriter.sv
module test_atm_cell_rewriter;
  localparam int CLK_PERIOD = 10;
  localparam int PAY        = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nni_mode = 1'b0, hec_pass = 1'b0;
  logic [1:0]  tag_size = '0;
  logic        in_valid = 1'b0, in_soc = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_soc, lk_req;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [27:0] lk_key;
  logic        lk_rsp_valid = 1'b0, lk_hit = 1'b0;
  logic [27:0] lk_new_id = '0;
  logic [23:0] lk_tag = '0;
  logic [1:0]  lk_clp_ctl = '0, lk_cong_ctl = '0;
  logic [15:0] drop_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_cell_rewriter i_atm_cell_rewriter (
    .clk(clk), .rst_n(rst_n), .nni_mode(nni_mode), .hec_pass(hec_pass),
    .tag_size(tag_size), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_soc(in_soc), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_soc(out_soc),
    .lk_req(lk_req), .lk_key(lk_key), .lk_rsp_valid(lk_rsp_valid),
    .lk_hit(lk_hit), .lk_new_id(lk_new_id), .lk_tag(lk_tag),
    .lk_clp_ctl(lk_clp_ctl), .lk_cong_ctl(lk_cong_ctl), .drop_count(drop_count)
  );

  int n_cmp = 0, n_bad = 0;
  int n_lookups = 0, exp_lookups = 0, n_miss = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lookup model settings
  logic        r_hit;
  logic [27:0] r_new, exp_key;
  logic [23:0] r_tag;
  logic [1:0]  r_clp, r_cong;
  int          r_lat = 0;
  bit          bp_on = 1'b0;

  initial forever begin
    @(negedge clk);
    if (rst_n && lk_req) begin
      chk("R1 lookup key", lk_key, exp_key);
      chk("R9 input stalled during lookup", in_ready, 1'b0);
      repeat (r_lat) @(negedge clk);
      chk("R9 request and key held", {lk_req, lk_key}, {1'b1, exp_key});
      lk_hit = r_hit; lk_new_id = r_new; lk_tag = r_tag;
      lk_clp_ctl = r_clp; lk_cong_ctl = r_cong; lk_rsp_valid = 1'b1;
      @(negedge clk);
      lk_rsp_valid = 1'b0;
      n_lookups++;
    end
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  logic [8:0] oq[$];
  bit         prev_stall = 1'b0;
  logic [8:0] prev_byte;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_stall)
        chk("R10 output held under stall", {out_valid, out_soc, out_data}, {1'b1, prev_byte});
      if (out_valid && out_ready) oq.push_back({out_soc, out_data});
      prev_stall = out_valid && !out_ready;
      prev_byte  = {out_soc, out_data};
    end
  end

  task automatic send_byte(input logic [7:0] d, input logic s);
    in_valid = 1'b1; in_data = d; in_soc = s;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_soc = 1'b0;
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] w);
    logic [39:0] m;
    m = {w, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
    return m[7:0] ^ 8'h55;
  endfunction

  function automatic logic mark(input logic [1:0] c, input logic b);
    return (c == 2'd1) ? 1'b1 : (c == 2'd2) ? 1'b0 : b;
  endfunction

  task automatic run_cell(input logic [31:0] hw, input logic [7:0] hec_in, input bit hit,
                          input bit nni, input bit hp, input int ts, input int garbage,
                          input bit abort, input logic [7:0] seed);
    logic [8:0] e[$];
    logic [31:0] nw;
    string req;
    nni_mode = nni; hec_pass = hp; tag_size = 2'(ts);
    r_hit = hit;
    exp_key = nni ? hw[31:4] : {4'h0, hw[27:4]};
    oq.delete();
    for (int g = 0; g < garbage; g++) send_byte(8'hC3 ^ 8'(g), 1'b0);
    if (abort) begin
      send_byte(8'h99, 1'b1);
      send_byte(8'h66, 1'b0);
    end
    send_byte(hw[31:24], 1'b1);
    send_byte(hw[23:16], 1'b0);
    send_byte(hw[15:8], 1'b0);
    send_byte(hw[7:0], 1'b0);
    send_byte(hec_in, 1'b0);
    exp_lookups++;
    for (int k = 0; k < PAY; k++) send_byte(seed + 8'(k * 3), 1'b0);
    repeat (3) @(negedge clk);
    if (!hit) begin
      n_miss++;
      chk("R8 no output for missed cell", oq.size(), 0);
      return;
    end
    for (int j = ts - 1; j >= 0; j--) e.push_back({1'b0, r_tag[8*j +: 8]});
    nw[31:28] = nni ? r_new[27:24] : hw[31:28];
    nw[27:4]  = r_new[23:0];
    nw[3]     = hw[3];
    nw[2]     = mark(r_cong, hw[2]);
    nw[1]     = hw[1];
    nw[0]     = mark(r_clp, hw[0]);
    for (int h = 3; h >= 0; h--) e.push_back({1'b0, nw[8*h +: 8]});
    e.push_back({1'b0, hp ? hec_in : ref_hec(nw)});
    for (int k = 0; k < PAY; k++) e.push_back({1'b0, seed + 8'(k * 3)});
    e[0][8] = 1'b1;
    chk("R7 output byte count", oq.size(), e.size());
    if (oq.size() == e.size())
      for (int i = 0; i < e.size(); i++) begin
        if (i < ts)             req = "R5 tag byte";
        else if (i == ts)       req = "R2 header byte0";
        else if (i < ts + 3)    req = "R2 header byte1-2";
        else if (i == ts + 3)   req = "R3 mark bits in byte3";
        else if (i == ts + 4)   req = "R4 check byte";
        else                    req = "R7 payload byte";
        chk(req, oq[i][7:0], e[i][7:0]);
        chk("R6 start flag", oq[i][8], e[i][8]);
      end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int idx;
    logic [31:0] hw;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R8 drop count zero after reset", drop_count, 16'd0);
    chk("R9 idle state at reset", {in_ready, out_valid, lk_req}, 3'b100);
    idx = 0;
    for (int nni = 0; nni < 2; nni++)
      for (int hp = 0; hp < 2; hp++)
        for (int ts = 0; ts < 4; ts++)
          for (int cl = 0; cl < 4; cl++)
            for (int cg = 0; cg < 4; cg++) begin
              r_new  = 28'(idx * 1234567 + 89);
              r_tag  = {8'(idx), 8'(~idx), 8'(idx ^ 8'h5A)};
              r_clp  = 2'(cl);
              r_cong = 2'(cg);
              r_lat  = idx % 4;
              bp_on  = (idx % 3) != 0;
              hw     = {8'(idx * 37), 8'(idx * 11 + 3), 8'(~idx), 8'(idx * 13 + 5)};
              run_cell(hw, 8'hA5 ^ 8'(idx), 1'b1, nni[0], hp[0], ts,
                       (idx % 7 == 0) ? 3 : 0, (idx % 9 == 4), 8'(idx * 5));
              idx++;
            end
    // missed cells, then a hit to show the stream recovers
    for (int m = 0; m < 4; m++) begin
      r_lat = m; bp_on = 1'b1;
      run_cell({8'(m), 24'h123456}, 8'h0F, 1'b0, m[0], 1'b0, 1, 0, 1'b0, 8'(m));
    end
    r_new = 28'hABCDEF1; r_tag = 24'h010203; r_clp = 2'd1; r_cong = 2'd2; r_lat = 2;
    run_cell(32'hFFFFFFFF, 8'h00, 1'b1, 1'b0, 1'b0, 3, 2, 1'b1, 8'hF0);
    chk("R8 drop counter total", drop_count, 16'(n_miss));
    chk("R11 one lookup per complete header", n_lookups, exp_lookups);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule